// File: doc/BRIEF.md
# Garbage Collection Victim Selector

This block tracks the page state of every erase block in a flash array and decides when space reclamation is needed and which block to reclaim next. For each block it keeps a count of valid pages, a count of invalid pages, the tick at which the block was last written, and how many times the block has been erased. Page-write, page-invalidate and block-erase events update these per-block records.

Reclamation is requested whenever the free-block count reported by the surrounding controller is below a threshold. While the request stands, the selector repeatedly walks all blocks, one per clock. Each walk ends with a one-cycle done pulse that carries the chosen victim index and a valid flag. Which block counts as the best candidate depends on a policy select: greedy, cost-benefit or cost-age-times. Every score is compared by cross-multiplying integers, so no division is needed. The selector does not move data or erase blocks itself; the caller does that and reports the erase back.

Top module: `gc_victim_sel`

## Requirements
- R1: `gc_req` is high exactly when `free_cnt` is strictly less than `gc_thresh`. It is combinational from those ports.
- R2: When no walk is running and `gc_req` is high at a clock edge, a walk starts on that edge. Walks keep restarting back to back for as long as `gc_req` stays high.
- R3: A walk visits blocks 0 to NBLK-1, one per cycle. `done` is high for one cycle, NBLK cycles after the start edge. `victim` and `victim_vld` change only together with `done` and hold their values until the next `done`.
- R4: A block is a candidate only if its invalid-page count is nonzero. This excludes blocks that are fully valid and blocks that are free. If no block qualifies, `victim_vld` is 0.
- R5: With `policy` = 0 or 3 (greedy), the victim is the candidate with the most invalid pages.
- R6: With `policy` = 1 (cost-benefit), the victim is the candidate with the largest age·invalid/valid. Candidate c replaces the current best b when age_c·inv_c·val_b > age_b·inv_b·val_c.
- R7: With `policy` = 2 (cost-age-times), the victim is the candidate with the smallest (valid/invalid)·erases/age. Candidate c replaces b when val_c·ers_c·age_b·inv_b < val_b·ers_b·age_c·inv_c.
- R8: On equal scores, the lower block index is kept.
- R9: A page write to a block raises its valid count by one and captures the current tick as its timestamp, unless valid+invalid already equals PAGES. A page invalidate moves one page from valid to invalid; it is ignored when the valid count is 0.
- R10: A block erase clears that block's valid and invalid counts, sets its timestamp to the current tick and increments its erase count (saturating). An erase takes priority over a write or invalidate to the same block in the same cycle.
- R11: A free-running tick counter starts at 0 after reset and advances every cycle. A block's age is the tick minus its timestamp.
- R12: After reset, `done`, `victim_vld` and `scan_busy` are 0, `victim` is 0, and all per-block counts and timestamps are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Page-invalidate event |
| inv_blk | input | $clog2(NBLK) | Block of the invalidated page |
| wr_valid | input | 1 | Page-write event |
| wr_blk | input | $clog2(NBLK) | Block of the written page |
| ers_valid | input | 1 | Block-erased event |
| ers_blk | input | $clog2(NBLK) | Erased block |
| free_cnt | input | FREE_W | Current number of free blocks |
| gc_thresh | input | FREE_W | Free-block threshold for reclamation |
| policy | input | 2 | 0/3 greedy, 1 cost-benefit, 2 cost-age-times |
| gc_req | output | 1 | Reclamation requested |
| scan_busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| victim | output | $clog2(NBLK) | Chosen block index |
| victim_vld | output | 1 | A candidate was found |

## Verification
The bench builds the selector with 4 blocks of 8 pages. With these values a block can be driven to fully valid, partly invalid or freshly erased in a handful of events, and a walk lasts only 4 cycles. Ages of a few hundred ticks are enough to make the cost-benefit and cost-age-times choices differ from the greedy one. The erase count reaches 3, which lets the erase term change a cost-age-times outcome. Ties on invalid counts and all-zero scores check that the lower index is kept.

// File: rtl/gc_victim_sel.sv
module gc_victim_sel #(
  parameter int NBLK   = 16,
  parameter int PAGES  = 64,
  parameter int TS_W   = 16,
  parameter int CLN_W  = 8,
  parameter int FREE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inv_valid,
  input  logic [$clog2(NBLK)-1:0] inv_blk,
  input  logic                    wr_valid,
  input  logic [$clog2(NBLK)-1:0] wr_blk,
  input  logic                    ers_valid,
  input  logic [$clog2(NBLK)-1:0] ers_blk,
  input  logic [FREE_W-1:0]       free_cnt,
  input  logic [FREE_W-1:0]       gc_thresh,
  input  logic [1:0]              policy,
  output logic                    gc_req,
  output logic                    scan_busy,
  output logic                    done,
  output logic [$clog2(NBLK)-1:0] victim,
  output logic                    victim_vld
);
  localparam int IW = $clog2(NBLK);
  localparam int CW = $clog2(PAGES + 1);
  localparam int PW = 2 * CW + TS_W + CLN_W;

  logic [NBLK-1:0][CW-1:0]    vcnt, icnt;
  logic [NBLK-1:0][TS_W-1:0]  tstamp;
  logic [NBLK-1:0][CLN_W-1:0] cln;
  logic [TS_W-1:0]            tick;

  assign gc_req = free_cnt < gc_thresh;

  always_ff @(posedge clk)
    if (!rst_n) tick <= '0;
    else        tick <= tick + 1'b1;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    logic [CW-1:0]    v_q, i_q;
    logic [TS_W-1:0]  t_q;
    logic [CLN_W-1:0] c_q;
    logic             ers_hit, inc, dec;

    assign ers_hit = ers_valid && (ers_blk == IW'(g));
    assign dec     = inv_valid && (inv_blk == IW'(g)) && (v_q != '0);
    assign inc     = wr_valid && (wr_blk == IW'(g)) &&
                     ((CW + 1)'(v_q) + (CW + 1)'(i_q) < (CW + 1)'(PAGES));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= '0;
        i_q <= '0;
        t_q <= '0;
        c_q <= '0;
      end else if (ers_hit) begin
        v_q <= '0;
        i_q <= '0;
        t_q <= tick;
        c_q <= c_q + CLN_W'(c_q != '1);
      end else begin
        v_q <= v_q + CW'(inc) - CW'(dec);
        i_q <= i_q + CW'(dec);
        if (inc) t_q <= tick;
      end
    end

    assign vcnt[g]   = v_q;
    assign icnt[g]   = i_q;
    assign tstamp[g] = t_q;
    assign cln[g]    = c_q;
  end

  logic [IW-1:0]    idx, best_idx;
  logic             have;
  logic [CW-1:0]    bv, bi;
  logic [TS_W-1:0]  bts;
  logic [CLN_W-1:0] bcl;

  logic [CW-1:0]    cv, ci;
  logic [TS_W-1:0]  age_c, age_b;
  logic [CLN_W-1:0] ccl;
  logic             elig, better, take;
  logic [PW-1:0]    cb_c, cb_b, ca_c, ca_b;

  assign cv    = vcnt[idx];
  assign ci    = icnt[idx];
  assign ccl   = cln[idx];
  assign age_c = tick - tstamp[idx];
  assign age_b = tick - bts;
  assign elig  = ci != '0;

  assign cb_c = PW'(age_c) * PW'(ci) * PW'(bv);
  assign cb_b = PW'(age_b) * PW'(bi) * PW'(cv);
  assign ca_c = PW'(cv) * PW'(ccl) * PW'(age_b) * PW'(bi);
  assign ca_b = PW'(bv) * PW'(bcl) * PW'(age_c) * PW'(ci);

  always_comb
    case (policy)
      2'd1:    better = cb_c > cb_b;
      2'd2:    better = ca_c < ca_b;
      default: better = ci > bi;
    endcase

  assign take = elig && (!have || better);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_busy  <= 1'b0;
      done       <= 1'b0;
      victim     <= '0;
      victim_vld <= 1'b0;
      idx        <= '0;
      have       <= 1'b0;
      best_idx   <= '0;
      bv         <= '0;
      bi         <= '0;
      bts        <= '0;
      bcl        <= '0;
    end else begin
      done <= 1'b0;
      if (!scan_busy) begin
        if (gc_req) begin
          scan_busy <= 1'b1;
          idx       <= '0;
          have      <= 1'b0;
        end
      end else begin
        if (take) begin
          have     <= 1'b1;
          best_idx <= idx;
          bv       <= cv;
          bi       <= ci;
          bts      <= tstamp[idx];
          bcl      <= ccl;
        end
        if (idx == IW'(NBLK - 1)) begin
          scan_busy  <= 1'b0;
          done       <= 1'b1;
          victim     <= take ? idx : best_idx;
          victim_vld <= have || take;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gc_victim_chk.sv
module gc_victim_chk #(
  parameter int NBLK = 16,
  parameter int CW   = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    gc_req,
  input logic                    scan_busy,
  input logic                    done,
  input logic [$clog2(NBLK)-1:0] victim,
  input logic                    victim_vld,
  input logic                    ers_valid,
  input logic [$clog2(NBLK)-1:0] ers_blk,
  input logic [NBLK-1:0][CW-1:0] vcnt,
  input logic [NBLK-1:0][CW-1:0] icnt
);
  localparam int KW = $clog2(NBLK + 1) + 1;
  logic [KW-1:0]           busy_cnt;
  logic [$clog2(NBLK)-1:0] ers_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      ers_q    <= '0;
    end else begin
      busy_cnt <= scan_busy ? busy_cnt + 1'b1 : '0;
      ers_q    <= ers_blk;
    end
  end

  a_r2_walk_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_busy && gc_req) |=> scan_busy);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_walk_length: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_cnt == KW'(NBLK));

  a_r3_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(victim) && $stable(victim_vld)));

  a_r10_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ers_valid |=> (vcnt[ers_q] == '0 && icnt[ers_q] == '0));
endmodule

bind gc_victim_sel gc_victim_chk #(.NBLK(NBLK), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .gc_req(gc_req), .scan_busy(scan_busy),
  .done(done), .victim(victim), .victim_vld(victim_vld),
  .ers_valid(ers_valid), .ers_blk(ers_blk), .vcnt(vcnt), .icnt(icnt)
);

// File: tb/test_gc_victim_sel.sv
module test_gc_victim_sel;
  localparam int N   = 4;
  localparam int P   = 8;
  localparam int IW  = 2;
  localparam int FW  = 8;
  localparam int THR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inv_valid = 0, wr_valid = 0, ers_valid = 0;
  logic [IW-1:0] inv_blk = 0, wr_blk = 0, ers_blk = 0;
  logic [FW-1:0] free_cnt = 8'd6, gc_thresh = 8'(THR);
  logic [1:0] policy = 0;
  logic gc_req, scan_busy, done, victim_vld;
  logic [IW-1:0] victim;

  gc_victim_sel #(.NBLK(N), .PAGES(P), .TS_W(16), .CLN_W(8), .FREE_W(FW)) i_gc_victim_sel (
    .clk(clk), .rst_n(rst_n), .inv_valid(inv_valid), .inv_blk(inv_blk),
    .wr_valid(wr_valid), .wr_blk(wr_blk), .ers_valid(ers_valid), .ers_blk(ers_blk),
    .free_cnt(free_cnt), .gc_thresh(gc_thresh), .policy(policy),
    .gc_req(gc_req), .scan_busy(scan_busy), .done(done),
    .victim(victim), .victim_vld(victim_vld));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [IW:0] exp_q[$];
  logic [IW:0] e;
  string tag_q[$];
  string t;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected done", 1, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(victim_vld == e[IW], {t, " victim_vld"}, int'(victim_vld), int'(e[IW]));
        if (e[IW]) chk(victim == e[IW-1:0], {t, " victim"}, int'(victim), int'(e[IW-1:0]));
      end
    end

  task automatic wr(input int b, input int n);
    repeat (n) begin @(negedge clk); wr_valid = 1; wr_blk = IW'(b); end
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic inv(input int b, input int n);
    repeat (n) begin @(negedge clk); inv_valid = 1; inv_blk = IW'(b); end
    @(negedge clk); inv_valid = 0;
  endtask

  task automatic ers(input int b);
    @(negedge clk); ers_valid = 1; ers_blk = IW'(b);
    @(negedge clk); ers_valid = 0;
  endtask

  task automatic scan(input int pol, input bit ev, input int ei, input string tag);
    int k;
    @(negedge clk);
    policy = 2'(pol);
    free_cnt = 8'(THR - 1);
    exp_q.push_back({ev, IW'(ei)});
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    free_cnt = 8'd6;
    k = 0;
    while (!done && k < 3 * N) begin @(negedge clk); k++; end
    chk(k == N, "R3 walk length", k, N);
    @(negedge clk);
    chk(!done, "R3 done pulse width", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 0 && victim_vld == 0 && scan_busy == 0, "R12 reset flags",
        int'({done, victim_vld, scan_busy}), 0);
    chk(victim == 0, "R12 reset victim", int'(victim), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!gc_req && !scan_busy, "R12 idle after reset", int'({gc_req, scan_busy}), 0);

    free_cnt = 8'(THR); #1;
    chk(gc_req == 0, "R1 at threshold", int'(gc_req), 0);
    free_cnt = 8'(THR - 1); #1;
    chk(gc_req == 1, "R1 below threshold", int'(gc_req), 1);
    free_cnt = 8'd6;

    // all blocks hold only valid pages
    wr(0, 8); wr(1, 8); wr(2, 8); wr(3, 4);
    scan(0, 0, 0, "R4 no invalid pages");

    inv(0, 2); inv(1, 5); inv(2, 5); inv(3, 1);
    scan(0, 1, 1, "R5 R8 greedy tie");

    repeat (300) @(negedge clk);
    wr(3, 4); inv(3, 5);
    scan(0, 1, 3, "R5 greedy");
    scan(3, 1, 3, "R5 greedy code 3");
    scan(1, 1, 1, "R6 R11 cost-benefit old block");
    scan(2, 1, 0, "R7 R8 zero-erase tie");

    ers(0); ers(1); ers(2); ers(3); ers(1); ers(1);
    inv(0, 1);
    scan(0, 0, 0, "R10 R9 R4 erased blocks");

    wr(0, 8); inv(0, 2);
    wr(1, 8); inv(1, 6);
    wr(2, 8); inv(2, 6);
    ers(3); wr(3, 8); inv(3, 6);
    repeat (50) @(negedge clk);
    scan(2, 1, 2, "R7 R10 R11 erase count");
    scan(1, 1, 1, "R6 R11 cost-benefit");
    scan(0, 1, 1, "R8 greedy tie");

    // R2: request held across two walks
    @(negedge clk);
    policy = 2'd2;
    free_cnt = 8'(THR - 1);
    repeat (2) begin exp_q.push_back({1'b1, 2'd2}); tag_q.push_back("R2 repeated walk"); end
    repeat (N + 2) @(posedge clk);
    @(negedge clk);
    free_cnt = 8'd6;
    repeat (3 * N) @(negedge clk);
    chk(exp_q.size() == 0, "R2 walks completed", exp_q.size(), 0);
    chk(!scan_busy, "R2 stops when request drops", int'(scan_busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule